// File: doc/BRIEF.md
# Generation-Tagged Event Queue Writer

This block appends one event word to a circular queue that lives in system memory. The queue is described by a base address, a size code, the current write index and a generation bit. On an event strobe the block forms a 32-bit entry that carries the generation bit on top of 31 bits of event data. It issues one big-endian write through a simple request/acknowledge memory port, waits for the response, and then reports the updated index and generation state for the caller to store back into the queue descriptor.

The generation bit flips each time the index wraps. A consumer can therefore tell fresh entries from stale ones by comparing bit 31 with the generation it expects, and no full or empty flags or shared read pointer are needed. A sticky "generation flipped" flag is passed through and takes the new generation value whenever a wrap happens.

The controller is a five-state machine:
- `S_IDLE` waits for an event. On an event with a legal size code it takes transition *accept* to `S_ISSUE`. On an event with an illegal code it takes transition *reject* to `S_CFG_FAIL`.
- `S_ISSUE` holds the memory request. It takes *error* to `S_WR_FAIL` when `mem_err` is high, and *ack* to `S_COMMIT` when only `mem_ack` is high.
- `S_COMMIT`, `S_WR_FAIL` and `S_CFG_FAIL` each last one cycle and take *finish* back to `S_IDLE`.

Top module: `eq_writer`

## Requirements
- R1: The queue holds 2^(size_code+10) four-byte entries. Index bits at or above bit size_code+10 are ignored, so the index is taken modulo the entry count.
- R2: The write address is the base address plus four times the (reduced) index.
- R3: The stored word has the generation bit in bit 31 and event data bits 30..0 in bits 30..0. Data bit 31 is dropped.
- R4: The word is presented big-endian on `mem_wdata`: bits 31..24 of the entry go on lane bits 7..0, bits 23..16 on 15..8, bits 15..8 on 23..16, and bits 7..0 on 31..24.
- R5: After a successful write, `next_index` is the reduced index plus one, modulo the entry count.
- R6: If that increment wraps to 0, `next_gen` is the inverted input generation and `next_gflip` equals the new generation. Without a wrap, both outputs pass the input values through.
- R7: On a memory error, `wr_err` is high with `done`, and `next_index`, `next_gen` and `next_gflip` equal the inputs.
- R8: A size code above IDX_W-10 is rejected. No memory request is made, `cfg_err` is high with `done` one cycle after the event, and the index and generation outputs equal the inputs.
- R9: An event is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle after `done`. Events while busy are ignored.
- R10: `mem_req` stays high with a stable address and data until `mem_ack` or `mem_err`. When both arrive in the same cycle, the response is treated as an error.
- R11: `done` is a single-cycle pulse in the cycle after the memory response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_data | input | 32 | Event data; bit 31 unused |
| q_base | input | ADDR_W | Queue base address |
| q_size | input | SIZE_W | Size code |
| q_index | input | IDX_W | Current write index |
| q_gen | input | 1 | Current generation bit |
| q_gflip | input | 1 | Current generation-flipped flag |
| busy | output | 1 | Event in progress |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 32 | Write data, big-endian lanes |
| mem_ack | input | 1 | Write completed |
| mem_err | input | 1 | Write failed |
| done | output | 1 | One-cycle completion pulse |
| wr_err | output | 1 | Memory error, with done |
| cfg_err | output | 1 | Illegal size code, with done |
| next_index | output | IDX_W | Updated index, valid with done |
| next_gen | output | 1 | Updated generation bit, valid with done |
| next_gflip | output | 1 | Updated generation-flipped flag, valid with done |

## Verification
The bench builds the block with IDX_W=12 and ADDR_W=32. This makes size codes 0, 1 and 2 the legal range, and codes 3 and 15 become reachable rejection cases. Queues of 1024 to 4096 entries make the last slot and the wrap of every legal size short to reach from a chosen index. The narrow index also lets an out-of-range index value exercise the modulo reduction directly.

// File: rtl/eqw_pkg.sv
package eqw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_COMMIT,
        S_WR_FAIL,
        S_CFG_FAIL
    } eqw_state_e;

    localparam int MIN_LOG_ENTRIES = 10;
    localparam int ENTRY_BYTES_LOG = 2;
    localparam int WORD_W          = 32;
endpackage

// File: rtl/eqw_slot_calc.sv
module eqw_slot_calc #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 20,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [IDX_W-1:0]  index,
    output logic              cfg_ok,
    output logic [IDX_W-1:0]  slot_mask,
    output logic [IDX_W-1:0]  eff_index,
    output logic [ADDR_W-1:0] slot_addr
);
    import eqw_pkg::*;

    localparam int MAX_CODE = IDX_W - MIN_LOG_ENTRIES;
    localparam int OFF_W    = IDX_W + ENTRY_BYTES_LOG;

    logic [OFF_W-1:0] byte_off;

    assign cfg_ok = (32'(size_code) <= 32'(MAX_CODE));

    for (genvar g = 0; g < IDX_W; g++) begin : g_mask
        assign slot_mask[g] = (32'(size_code) + 32'(MIN_LOG_ENTRIES)) > 32'(g);
    end

    assign eff_index = index & slot_mask;
    assign byte_off  = {eff_index, {ENTRY_BYTES_LOG{1'b0}}};
    assign slot_addr = base + ADDR_W'(byte_off);
endmodule

// File: rtl/eqw_word_pack.sv
module eqw_word_pack #(
    parameter int LANES = 4
) (
    input  logic               gen,
    input  logic [8*LANES-1:0] data,
    output logic [8*LANES-1:0] lane_data
);
    logic [8*LANES-1:0] entry;

    assign entry = {gen, data[8*LANES-2:0]};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_data[8*k +: 8] = entry[8*(LANES-1-k) +: 8];
    end
endmodule

// File: rtl/eqw_index_step.sv
module eqw_index_step #(
    parameter int IDX_W = 20
) (
    input  logic [IDX_W-1:0] cur_index,
    input  logic [IDX_W-1:0] slot_mask,
    input  logic             cur_gen,
    input  logic             cur_gflip,
    output logic [IDX_W-1:0] adv_index,
    output logic             adv_gen,
    output logic             adv_gflip
);
    logic wrapped;

    assign adv_index = (cur_index + IDX_W'(1)) & slot_mask;
    assign wrapped   = (adv_index == '0);
    assign adv_gen   = cur_gen ^ wrapped;
    assign adv_gflip = wrapped ? adv_gen : cur_gflip;
endmodule

// File: rtl/eq_writer.sv
module eq_writer #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 20,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [31:0]       ev_data,
    input  logic [ADDR_W-1:0] q_base,
    input  logic [SIZE_W-1:0] q_size,
    input  logic [IDX_W-1:0]  q_index,
    input  logic              q_gen,
    input  logic              q_gflip,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              done,
    output logic              wr_err,
    output logic              cfg_err,
    output logic [IDX_W-1:0]  next_index,
    output logic              next_gen,
    output logic              next_gflip
);
    import eqw_pkg::*;

    localparam int LANES = WORD_W / 8;

    eqw_state_e state_q, state_d;

    logic              cfg_ok;
    logic [IDX_W-1:0]  slot_mask;
    logic [IDX_W-1:0]  eff_index;
    logic [ADDR_W-1:0] slot_addr;
    logic [31:0]       lane_data;
    logic [IDX_W-1:0]  adv_index;
    logic              adv_gen;
    logic              adv_gflip;

    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       wdata_q;
    logic [IDX_W-1:0]  orig_idx_q, adv_idx_q;
    logic              orig_gen_q, adv_gen_q;
    logic              orig_gf_q,  adv_gf_q;

    logic              accept;

    eqw_slot_calc #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .SIZE_W (SIZE_W)
    ) u_slot (
        .base      (q_base),
        .size_code (q_size),
        .index     (q_index),
        .cfg_ok    (cfg_ok),
        .slot_mask (slot_mask),
        .eff_index (eff_index),
        .slot_addr (slot_addr)
    );

    eqw_word_pack #(
        .LANES (LANES)
    ) u_pack (
        .gen       (q_gen),
        .data      (ev_data),
        .lane_data (lane_data)
    );

    eqw_index_step #(
        .IDX_W (IDX_W)
    ) u_step (
        .cur_index (eff_index),
        .slot_mask (slot_mask),
        .cur_gen   (q_gen),
        .cur_gflip (q_gflip),
        .adv_index (adv_index),
        .adv_gen   (adv_gen),
        .adv_gflip (adv_gflip)
    );

    assign accept = (state_q == S_IDLE) && ev_valid;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (ev_valid) state_d = cfg_ok ? S_ISSUE : S_CFG_FAIL;
            end
            S_ISSUE: begin
                if (mem_err)      state_d = S_WR_FAIL;
                else if (mem_ack) state_d = S_COMMIT;
            end
            S_COMMIT:   state_d = S_IDLE;
            S_WR_FAIL:  state_d = S_IDLE;
            S_CFG_FAIL: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // event capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            orig_idx_q <= '0;
            orig_gen_q <= 1'b0;
            orig_gf_q  <= 1'b0;
            adv_idx_q  <= '0;
            adv_gen_q  <= 1'b0;
            adv_gf_q   <= 1'b0;
        end else if (accept) begin
            addr_q     <= slot_addr;
            wdata_q    <= lane_data;
            orig_idx_q <= q_index;
            orig_gen_q <= q_gen;
            orig_gf_q  <= q_gflip;
            adv_idx_q  <= adv_index;
            adv_gen_q  <= adv_gen;
            adv_gf_q   <= adv_gflip;
        end
    end

    // outputs decoded from state
    always_comb begin
        busy       = 1'b1;
        mem_req    = 1'b0;
        done       = 1'b0;
        wr_err     = 1'b0;
        cfg_err    = 1'b0;
        next_index = orig_idx_q;
        next_gen   = orig_gen_q;
        next_gflip = orig_gf_q;
        unique case (state_q)
            S_IDLE:  busy = 1'b0;
            S_ISSUE: mem_req = 1'b1;
            S_COMMIT: begin
                done       = 1'b1;
                next_index = adv_idx_q;
                next_gen   = adv_gen_q;
                next_gflip = adv_gf_q;
            end
            S_WR_FAIL: begin
                done   = 1'b1;
                wr_err = 1'b1;
            end
            S_CFG_FAIL: begin
                done    = 1'b1;
                cfg_err = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
endmodule

// File: rtl/eq_writer_chk.sv
module eq_writer_chk #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              done,
    input logic              wr_err,
    input logic              cfg_err,
    input logic [IDX_W-1:0]  next_index,
    input logic              next_gen,
    input logic              next_gflip
);
    // R10: request held with stable payload until a response
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R11: response is followed by done
    a_r11_resp_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_ack || mem_err)) |=> done);

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7 / R10: error response yields wr_err
    a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (done && wr_err));

    // R9: no activity starts without an event
    a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ev_valid) |=> !busy);

    // R8: rejection is never preceded by a request
    a_r8_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_err) |-> !$past(mem_req));

    // R6: on a wrap the flipped flag follows the new generation
    a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_err && !cfg_err && next_index == '0) |-> (next_gflip == next_gen));
endmodule

bind eq_writer eq_writer_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .done       (done),
    .wr_err     (wr_err),
    .cfg_err    (cfg_err),
    .next_index (next_index),
    .next_gen   (next_gen),
    .next_gflip (next_gflip)
);

// File: tb/tb_eq_writer.sv
`timescale 1ns/1ps
module tb_eq_writer;
    localparam int AW = 32;
    localparam int IW = 12;
    localparam int NV = 8;

    typedef struct packed {
        logic [3:0]    size;
        logic [IW-1:0] idx;
        logic          gen;
        logic          gf;
        logic [31:0]   data;
        logic [AW-1:0] base;
        logic          err;
        logic [AW-1:0] e_addr;
        logic [31:0]   e_wdata;
        logic [IW-1:0] e_idx;
        logic          e_gen;
        logic          e_gf;
    } vec_t;

    // R1..R7 vectors: stimulus and expected results
    localparam vec_t VECS [NV] = '{
        '{4'd0, 12'd5,    1'b0, 1'b0, 32'h8000_0ABC, 32'h0001_0000, 1'b0, 32'h0001_0014, 32'hBC0A_0000, 12'd6,    1'b0, 1'b0},
        '{4'd0, 12'd1023, 1'b0, 1'b0, 32'h1234_5678, 32'h0001_0000, 1'b0, 32'h0001_0FFC, 32'h7856_3412, 12'd0,    1'b1, 1'b1},
        '{4'd0, 12'd1023, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0001_0000, 1'b0, 32'h0001_0FFC, 32'hFFFF_FFFF, 12'd0,    1'b0, 1'b0},
        '{4'd1, 12'd1023, 1'b1, 1'b0, 32'h0000_0001, 32'h2000_0000, 1'b0, 32'h2000_0FFC, 32'h0100_0080, 12'd1024, 1'b1, 1'b0},
        '{4'd2, 12'd4095, 1'b0, 1'b1, 32'h7FFF_0000, 32'h0000_4000, 1'b0, 32'h0000_7FFC, 32'h0000_FF7F, 12'd0,    1'b1, 1'b1},
        '{4'd1, 12'd7,    1'b1, 1'b1, 32'hCAFE_F00D, 32'h2000_0000, 1'b1, 32'h2000_001C, 32'h0DF0_FECA, 12'd7,    1'b1, 1'b1},
        '{4'd2, 12'd0,    1'b0, 1'b0, 32'h0000_0000, 32'h0000_4000, 1'b0, 32'h0000_4000, 32'h0000_0000, 12'd1,    1'b0, 1'b0},
        '{4'd0, 12'h405,  1'b0, 1'b0, 32'h0000_0001, 32'h0001_0000, 1'b0, 32'h0001_0014, 32'h0100_0000, 12'd6,    1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [31:0]   ev_data = '0;
    logic [AW-1:0] q_base = '0;
    logic [3:0]    q_size = '0;
    logic [IW-1:0] q_index = '0;
    logic          q_gen = 1'b0;
    logic          q_gflip = 1'b0;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;
    logic          busy, mem_req, done, wr_err, cfg_err, next_gen, next_gflip;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [IW-1:0] next_index;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    eq_writer #(.ADDR_W(AW), .IDX_W(IW), .SIZE_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_data(ev_data),
        .q_base(q_base), .q_size(q_size), .q_index(q_index), .q_gen(q_gen),
        .q_gflip(q_gflip), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .done(done),
        .wr_err(wr_err), .cfg_err(cfg_err), .next_index(next_index),
        .next_gen(next_gen), .next_gflip(next_gflip)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        q_size  = v.size;
        q_index = v.idx;
        q_gen   = v.gen;
        q_gflip = v.gf;
        ev_data = v.data;
        q_base  = v.base;
    endtask

    task automatic run_vec(input vec_t v, input bit both);
        @(negedge clk);
        load(v);
        ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        chk(mem_req && busy, "R9 request raised", {62'd0, mem_req, busy}, 64'd3);
        chk(mem_addr == v.e_addr, "R2/R1 address", 64'(mem_addr), 64'(v.e_addr));
        chk(mem_wdata == v.e_wdata, "R3/R4 word", 64'(mem_wdata), 64'(v.e_wdata));
        @(negedge clk);
        chk(mem_req && mem_addr == v.e_addr, "R10 request held", 64'(mem_addr), 64'(v.e_addr));
        mem_ack = !v.err || both;
        mem_err = v.err;
        @(negedge clk);
        mem_ack = 1'b0;
        mem_err = 1'b0;
        chk(done && !mem_req && wr_err == v.err && !cfg_err, "R11/R7 done flags",
            {60'd0, done, mem_req, wr_err, cfg_err}, {60'd0, 1'b1, 1'b0, v.err, 1'b0});
        chk(next_index == v.e_idx && next_gen == v.e_gen && next_gflip == v.e_gf,
            "R5/R6/R7 next state", {50'd0, next_index, next_gen, next_gflip},
            {50'd0, v.e_idx, v.e_gen, v.e_gf});
        @(negedge clk);
        chk(!done && !busy, "R11/R9 back to idle", {62'd0, done, busy}, 64'd0);
    endtask

    task automatic cfg_case(input logic [3:0] sz);
        @(negedge clk);
        q_size  = sz;
        q_index = 12'd33;
        q_gen   = 1'b1;
        q_gflip = 1'b0;
        ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        chk(done && cfg_err && !mem_req && !wr_err, "R8 reject flags",
            {60'd0, done, cfg_err, mem_req, wr_err}, {60'd0, 4'b1100});
        chk(next_index == 12'd33 && next_gen && !next_gflip, "R8 state unchanged",
            {50'd0, next_index, next_gen, next_gflip}, {50'd0, 12'd33, 1'b1, 1'b0});
        @(negedge clk);
        chk(!busy && !mem_req, "R8 no request follows", {62'd0, busy, mem_req}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done, "R9 reset state", {61'd0, busy, mem_req, done}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R10: simultaneous ack and error counts as error
        run_vec(VECS[5], 1'b1);

        // R8: sizes beyond the legal range
        cfg_case(4'd3);
        cfg_case(4'd15);

        // R9: event while busy is ignored
        @(negedge clk);
        load(VECS[0]);
        ev_valid = 1'b1;
        @(negedge clk);
        load(VECS[3]);
        @(negedge clk);
        ev_valid = 1'b0;
        chk(mem_addr == VECS[0].e_addr && mem_wdata == VECS[0].e_wdata, "R9 busy ignores event",
            64'(mem_addr), 64'(VECS[0].e_addr));
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk(done && next_index == VECS[0].e_idx, "R9 first event result",
            64'(next_index), 64'(VECS[0].e_idx));
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req, "R9 no second request", {62'd0, busy, mem_req}, 64'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule